// File: doc/BRIEF.md
# Cascadable Event Down-Counter Bank

This block is a bank of reloadable 16-bit down-counters. Each counter counts events and loses one count per event. An event is either an edge on that counter's external input or an underflow pulse from a neighbouring counter in the bank. On underflow, a counter takes its value from its reload register, keeps counting, and raises an interrupt request for one clock.

Each counter has its own controls:
- a run bit;
- a source select;
- a two-bit edge select;
- a write strobe.

The bank shares one write data bus. Whether a write reaches both the counter and the reload register, or only the reload register, depends on whether the counter has seen an event since it was last started.

The six counters form two cascade rings of three. Counter k counts the underflows of counter k-1 within its ring, and the first member of each ring counts the underflows of the last member. This lets software chain counters into longer dividers.

Top module: `evt_timer_bank`

## Requirements
- R1: While running, each count event lowers the counter value by exactly one, unless the value is zero.
- R2: A count event at value zero loads the reload register into the counter. A loaded value n therefore gives one underflow every n+1 events, for n from 0 to 65535.
- R3: Each underflow drives that counter's `irq` bit high for exactly one clock. The pulse appears in the same cycle in which the reloaded value appears on `count_out`.
- R4: While the `start` bit of a counter is 0, events have no effect on its count value.
- R5: A write to a stopped counter loads both the counter and the reload register. So does a write to a running counter that has not yet counted an event since its `start` went from 0 to 1.
- R6: After the first event since start, a write changes only the reload register. The written value reaches the counter at the next underflow.
- R7: With `src_sel`=0, the counter's `edge_sel` field sets which edges of the synchronized external input are counted: 00 counts falling edges, 01 counts rising edges, 10 counts both edges, and 11 counts nothing.
- R8: With `src_sel`=1, the counter counts underflow pulses from its cascade neighbour. Its external input and its `edge_sel` field are then ignored.
- R9: The cascade neighbour map is 0<-2, 1<-0, 2<-1, 3<-5, 4<-3, 5<-4.
- R10: A write and a count event can coincide while the counter is still in the phase described in R5. In that case the written value wins, the event is dropped, and the counter stays in that phase.
- R11: `count_out` always shows the current value of every counter. All counters reset to zero with no interrupt pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_in | input | 6 | External event input per counter; asynchronous |
| start | input | 6 | Run bit per counter |
| src_sel | input | 6 | Source select per counter: 0 selects the external input, 1 selects the cascade neighbour |
| edge_sel | input | 12 | Edge select, two bits per counter (counter k uses bits [2k+1:2k]) |
| wr_en | input | 6 | Write strobe per counter |
| wr_data | input | 16 | Shared write data |
| count_out | output | 96 | Live count values; counter k is on bits [16k+15:16k] |
| irq | output | 6 | One-cycle underflow request per counter |

## Verification
Some properties are checked on every cycle by the assertions:
- the decrement by one per event;
- reload on underflow, with an `irq` only after an event at zero;
- the count holding while a counter is stopped;
- the count holding while a reload-only write takes place;
- no event from the reserved edge code.

Other behaviours need the bench's directed scenarios:
- the edge encodings against real input waveforms;
- the division ratio over several underflow periods;
- the two write phases around start and the first event;
- the write-over-event collision;
- the six-entry cascade map with its ring wrap.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_mode_e;

  function automatic int ring_source(input int idx, input int ring);
    int base;
    base = (idx / ring) * ring;
    return base + (((idx % ring) + ring - 1) % ring);
  endfunction

endpackage

// File: rtl/evt_src_select.sv
module evt_src_select
  import evt_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_in,
  input  logic       casc_in,
  input  logic       src_sel,
  input  logic [1:0] edge_sel,
  output logic       ev_o
);

  logic sync1_q, sync2_q, prev_q;
  logic edge_ev;
  edge_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= ext_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    mode = edge_mode_e'(edge_sel);
    unique case (mode)
      EDGE_FALL: edge_ev = prev_q & ~sync2_q;
      EDGE_RISE: edge_ev = sync2_q & ~prev_q;
      EDGE_BOTH: edge_ev = sync2_q ^ prev_q;
      default:   edge_ev = 1'b0;
    endcase
  end

  assign ev_o = src_sel ? casc_in : edge_ev;

  // R7
  rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_sel && edge_sel == 2'b11) |-> !ev_o);

  // R8
  casc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && !casc_in) |-> !ev_o);

endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ev_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, reload_q, reload_d;
  logic             first_q, first_d, start_q, irq_q, irq_d;
  logic             ev, start_rise, wr_both;

  assign ev         = start & ev_in;
  assign start_rise = start & ~start_q;
  assign wr_both    = ~start | ~first_q | start_rise;

  always_comb begin
    cnt_d    = cnt_q;
    reload_d = reload_q;
    first_d  = first_q;
    irq_d    = 1'b0;
    if (wr_en && wr_both) begin
      cnt_d    = wr_data;
      reload_d = wr_data;
      if (start_rise) first_d = 1'b0;
    end else begin
      if (wr_en) reload_d = wr_data;
      if (start_rise) first_d = 1'b0;
      if (ev) begin
        first_d = 1'b1;
        if (cnt_q == '0) begin
          cnt_d = reload_d;
          irq_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      first_q  <= 1'b0;
      start_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
      first_q  <= first_d;
      start_q  <= start;
      irq_q    <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R1
  dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !wr_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !wr_en && cnt_q == '0) |=> (cnt_q == $past(reload_q)));

  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(ev) && $past(cnt_q) == '0));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !wr_en) |=> $stable(cnt_q));

  // R6
  reload_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && start && start_q && first_q && !ev) |=> $stable(cnt_q));

endmodule

// File: rtl/evt_timer_bank.sv
module evt_timer_bank
  import evt_tmr_pkg::*;
#(
  parameter int NUM_TMR = 6,
  parameter int RING    = 3,
  parameter int CNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_TMR-1:0]       ext_in,
  input  logic [NUM_TMR-1:0]       start,
  input  logic [NUM_TMR-1:0]       src_sel,
  input  logic [2*NUM_TMR-1:0]     edge_sel,
  input  logic [NUM_TMR-1:0]       wr_en,
  input  logic [CNT_W-1:0]         wr_data,
  output logic [NUM_TMR*CNT_W-1:0] count_out,
  output logic [NUM_TMR-1:0]       irq
);

  logic rst_s1_q, rst_s2_q;
  logic [NUM_TMR-1:0] ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    localparam int SRC = ring_source(k, RING);

    evt_src_select u_src (
      .clk      (clk),
      .rst_n    (rst_s2_q),
      .ext_in   (ext_in[k]),
      .casc_in  (irq[SRC]),
      .src_sel  (src_sel[k]),
      .edge_sel (edge_sel[2*k +: 2]),
      .ev_o     (ev[k])
    );

    evt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_s2_q),
      .start   (start[k]),
      .wr_en   (wr_en[k]),
      .wr_data (wr_data),
      .ev_in   (ev[k]),
      .cnt_o   (count_out[k*CNT_W +: CNT_W]),
      .irq_o   (irq[k])
    );
  end

endmodule

// File: tb/evt_timer_bank_test.sv
module evt_timer_bank_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  ext_in, start, src_sel, wr_en, irq;
  logic [11:0] edge_sel;
  logic [15:0] wr_data;
  logic [95:0] count_out;
  int checks = 0;
  int errors = 0;
  int irq_cnt [6];

  always #4 clk = ~clk;

  evt_timer_bank uut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .start(start),
    .src_sel(src_sel), .edge_sel(edge_sel), .wr_en(wr_en),
    .wr_data(wr_data), .count_out(count_out), .irq(irq)
  );

  always @(negedge clk)
    for (int k = 0; k < 6; k++) if (irq[k] === 1'b1) irq_cnt[k]++;

  function automatic logic [15:0] cnt(input int ch);
    return count_out[ch*16 +: 16];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [15:0] d);
    @(negedge clk); wr_en[ch] = 1'b1; wr_data = d;
    @(negedge clk); wr_en[ch] = 1'b0;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); ext_in[ch] = 1'b1;
    repeat (4) @(negedge clk);
    ext_in[ch] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mode(input int ch, input logic s, input logic [1:0] e);
    src_sel[ch] = s; edge_sel[2*ch +: 2] = e;
  endtask

  task automatic t_reset();
    for (int k = 0; k < 6; k++) check("R11 reset count", cnt(k), 0);
    check("R11 reset irq", irq, 0);
  endtask

  task automatic t_rise_and_phases();
    int i0;
    set_mode(0, 0, 2'b01);
    wr(0, 16'd3);
    check("R5 stopped write", cnt(0), 3);
    @(negedge clk); start[0] = 1'b1;
    wr(0, 16'd6);
    check("R5 write before first event", cnt(0), 6);
    pulse(0);
    check("R1 rise decrement", cnt(0), 5);
    wr(0, 16'd10);
    check("R6 reload-only write", cnt(0), 5);
    repeat (5) pulse(0);
    check("R1 count to zero", cnt(0), 0);
    i0 = irq_cnt[0];
    pulse(0);
    check("R6 new reload reaches counter", cnt(0), 10);
    check("R3 one irq per underflow", irq_cnt[0] - i0, 1);
    @(negedge clk); start[0] = 1'b0;
  endtask

  task automatic t_ratio();
    int i0;
    wr(0, 16'd2);
    @(negedge clk); start[0] = 1'b1;
    i0 = irq_cnt[0];
    repeat (6) pulse(0);
    check("R2 ratio n+1 irqs", irq_cnt[0] - i0, 2);
    check("R2 count after reloads", cnt(0), 2);
    @(negedge clk); start[0] = 1'b0;
  endtask

  task automatic t_irq_width();
    int hi;
    wr(0, 16'd0);
    @(negedge clk); start[0] = 1'b1;
    ext_in[0] = 1'b1;
    hi = 0;
    repeat (6) begin @(negedge clk); if (irq[0]) hi++; end
    check("R3 irq lasts one clock", hi, 1);
    ext_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    start[0] = 1'b0;
  endtask

  task automatic t_fall_both_rsvd();
    set_mode(2, 0, 2'b00);
    wr(2, 16'd5);
    @(negedge clk); start[2] = 1'b1;
    @(negedge clk); ext_in[2] = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 fall mode ignores rise", cnt(2), 5);
    ext_in[2] = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 fall mode counts fall", cnt(2), 4);
    set_mode(2, 0, 2'b10);
    pulse(2);
    check("R7 both edges", cnt(2), 2);
    set_mode(2, 0, 2'b11);
    pulse(2);
    check("R7 reserved counts nothing", cnt(2), 2);
    @(negedge clk); start[2] = 1'b0;
    set_mode(2, 0, 2'b01);
    pulse(2);
    check("R4 stopped ignores events", cnt(2), 2);
  endtask

  task automatic t_collision();
    set_mode(4, 0, 2'b01);
    wr(4, 16'd3);
    @(negedge clk); start[4] = 1'b1; ext_in[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en[4] = 1'b1; wr_data = 16'd7;
    @(negedge clk); wr_en[4] = 1'b0;
    check("R10 write wins over event", cnt(4), 7);
    wr(4, 16'd9);
    check("R10 still in write-both phase", cnt(4), 9);
    @(negedge clk); ext_in[4] = 1'b0;
    repeat (4) @(negedge clk);
    pulse(4);
    check("R10 later event counts", cnt(4), 8);
    @(negedge clk); start[4] = 1'b0;
  endtask

  task automatic t_cascade();
    set_mode(0, 0, 2'b01); wr(0, 16'd0);
    set_mode(1, 1, 2'b01); wr(1, 16'd5);
    @(negedge clk); start[0] = 1'b1; start[1] = 1'b1;
    repeat (3) pulse(0);
    check("R9 ring 1<-0", cnt(1), 2);
    pulse(1);
    check("R8 external ignored in cascade", cnt(1), 2);
    set_mode(5, 0, 2'b01); wr(5, 16'd0);
    set_mode(3, 1, 2'b00); wr(3, 16'd4);
    @(negedge clk); start[5] = 1'b1; start[3] = 1'b1;
    repeat (2) pulse(5);
    check("R9 ring wrap 3<-5", cnt(3), 2);
    check("R9 ring isolation", cnt(1), 2);
    @(negedge clk); start = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) irq_cnt[k] = 0;
    rst_n = 1'b0; ext_in = '0; start = '0; src_sel = '0;
    edge_sel = {6{2'b01}}; wr_en = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rise_and_phases();
    t_ratio();
    t_irq_width();
    t_fall_both_rsvd();
    t_collision();
    t_cascade();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule